// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block runs an 8-bit general-purpose I/O port behind a small register bus. Software writes a per-bit direction register, an output data register, a per-bit read mask, a two-bit override register and a per-bit testpoint enable. The controller derives each pad's output value and output enable from these. The testpoint enable has the highest priority. The override comes next and applies only to bits 0 and 1, where it routes an external clock-master enable onto the pad. The plain output data register comes last.

Pad inputs pass through a two-flop synchronizer. The synchronized levels go to an external interrupt controller and can also be read back through the bus, with masked bits forced to zero. The bus has an address, a write strobe and write data. Read data is registered and appears one cycle after the address is presented.

Register map (3-bit address): 0 direction, 1 output data, 2 read mask, 3 override, 4 testpoint enable, 5 pin level (read-only), 6 and 7 unmapped.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0, pad_oe is 0 on all bits and bus_rdata is 0.
- R2: With override and testpoint off on a bit, pad_oe of that bit equals its direction bit (1 = output), and pad_out carries the output data bit whenever pad_oe is 1.
- R3: A write to address 0, 1, 2 or 4 stores bus_wdata, and a later read of the same address returns it.
- R4: A read of address 5 returns the synchronized pad level with every bit that is set in the read mask forced to 0.
- R5: Override bit 0 forces pad_oe[0]=1 with pad_out[0]=clkm_a_en; override bit 1 forces pad_oe[1]=1 with pad_out[1]=clkm_b_en, whatever the direction bits are.
- R6: Bits 7:2 of a write to the override register (address 3) are ignored: they read back as 0 and do not affect pads 2 to 7.
- R7: A set testpoint enable bit forces that pad's pad_oe to 1 and pad_out to the matching tp_sig bit, ahead of both override and direction.
- R8: irq_lvl equals pad_in delayed by exactly two clock cycles.
- R9: bus_rdata shows the register selected by the address of the previous cycle. Addresses 6 and 7 read 0, and writes to addresses 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the address |
| clkm_a_en | input | 1 | A-clock master enable state, routed to pad 0 under override |
| clkm_b_en | input | 1 | B-clock master enable state, routed to pad 1 under override |
| tp_sig | input | 8 | Internal testpoint signals, one per pad |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| irq_lvl | output | 8 | Synchronized pad levels for the interrupt controller |

## Verification
The assertions check on every cycle the timing relations visible at the ports. irq_lvl must follow pad_in two cycles later. A pin-level read may show only bits that are high on the synchronized inputs. Unmapped reads and the upper override bits must return zero. Outputs must be clear right after reset. The drive priority among testpoint, override and direction, the storage of each register, and the effect of individual mask bits are shown only by the bench. The bench writes random register settings and compares the pads and the read data with values it computes itself.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GP_WIDTH  = 8;
    localparam int GP_ADDR_W = 3;
    localparam int GP_OVR_N  = 2;

    typedef enum logic [GP_ADDR_W-1:0] {
        SEL_DIR   = 3'd0,
        SEL_DOUT  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_OVR   = 3'd3,
        SEL_TPEN  = 3'd4,
        SEL_LEVEL = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drive_t;

    // Per-bit priority: testpoint, then override, then plain GPIO.
    function automatic pad_drive_t pick_drive(
        input logic tp_on, input logic ovr_on, input logic dir_out,
        input logic tp_v,  input logic ovr_v,  input logic dat_v);
        pad_drive_t d;
        if (tp_on) begin
            d.oe  = 1'b1;
            d.val = tp_v;
        end else if (ovr_on) begin
            d.oe  = 1'b1;
            d.val = ovr_v;
        end else begin
            d.oe  = dir_out;
            d.val = dat_v;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W     = GP_WIDTH,
    parameter int AW    = GP_ADDR_W,
    parameter int OVR_N = GP_OVR_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_level,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  dout_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  ovr_q,
    output logic [W-1:0]  tpen_q
);

    logic [W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            dout_q <= '0;
            mask_q <= '0;
            tpen_q <= '0;
        end else if (wr_en) begin
            case (addr)
                SEL_DIR:  dir_q  <= wdata;
                SEL_DOUT: dout_q <= wdata;
                SEL_MASK: mask_q <= wdata;
                SEL_TPEN: tpen_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Only the lowest OVR_N bits of the override register exist.
    for (genvar i = 0; i < W; i++) begin : g_ovr
        if (i < OVR_N) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    ovr_q[i] <= 1'b0;
                else if (wr_en && addr == SEL_OVR)
                    ovr_q[i] <= wdata[i];
            end
        end else begin : g_tie
            assign ovr_q[i] = 1'b0;
        end
    end

    always_comb begin
        case (addr)
            SEL_DIR:   rd_mux = dir_q;
            SEL_DOUT:  rd_mux = dout_q;
            SEL_MASK:  rd_mux = mask_q;
            SEL_OVR:   rd_mux = ovr_q;
            SEL_TPEN:  rd_mux = tpen_q;
            SEL_LEVEL: rd_mux = pin_level & ~mask_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) stage_q[s] <= d_async;
        end else begin : g_next
            always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int W = GP_WIDTH
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] dout_q,
    input  logic [W-1:0] ovr_q,
    input  logic [W-1:0] ovr_src,
    input  logic [W-1:0] tpen_q,
    input  logic [W-1:0] tp_sig,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        pad_drive_t drv;
        always_comb begin
            drv = pick_drive(tpen_q[i], ovr_q[i], dir_q[i],
                             tp_sig[i], ovr_src[i], dout_q[i]);
        end
        assign pad_out[i] = drv.val;
        assign pad_oe[i]  = drv.oe;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int W  = GP_WIDTH,
    parameter int AW = GP_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic          clkm_a_en,
    input  logic          clkm_b_en,
    input  logic [W-1:0]  tp_sig,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  irq_lvl
);

    localparam int SYNC_STAGES = 2;

    logic [W-1:0] dir_q, dout_q, mask_q, ovr_q, tpen_q;
    logic [W-1:0] level_s;
    logic [W-1:0] ovr_src;

    always_comb begin
        ovr_src    = '0;
        ovr_src[0] = clkm_a_en;
        ovr_src[1] = clkm_b_en;
    end

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (pad_in),
        .d_sync  (level_s)
    );

    gpio_regfile #(.W(W), .AW(AW), .OVR_N(GP_OVR_N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr_en     (bus_wr),
        .wdata     (bus_wdata),
        .pin_level (level_s),
        .rdata     (bus_rdata),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .mask_q    (mask_q),
        .ovr_q     (ovr_q),
        .tpen_q    (tpen_q)
    );

    gpio_pad_mux #(.W(W)) u_mux (
        .dir_q   (dir_q),
        .dout_q  (dout_q),
        .ovr_q   (ovr_q),
        .ovr_src (ovr_src),
        .tpen_q  (tpen_q),
        .tp_sig  (tp_sig),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign irq_lvl = level_s;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pad_in,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  irq_lvl
);

    logic [1:0] cyc;
    logic       rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)            cyc <= 2'd0;
        else if (cyc != 3)  cyc <= cyc + 2'd1;
    end

    // R1: outputs clear in the first cycle out of reset
    always @(posedge clk) begin
        if (rst_d && !rst)
            p_reset_clear_r1: assert (pad_oe == '0 && bus_rdata == '0);
    end

    // R8: two-cycle synchronizer latency
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2) |-> (irq_lvl == $past(pad_in, 2)));

    // R4: a pin-level read shows only bits high on the synchronized input
    p_level_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 1 && $past(bus_addr) == 3'd5) |-> ((bus_rdata & ~$past(irq_lvl)) == '0));

    // R9: unmapped addresses read zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 1 && $past(bus_addr) >= 3'd6) |-> (bus_rdata == '0));

    // R6: upper override bits never read back
    p_ovr_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 1 && $past(bus_addr) == 3'd3) |-> (bus_rdata[W-1:2] == '0));

endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .irq_lvl   (irq_lvl)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       clkm_a_en = 1'b0, clkm_b_en = 1'b0;
    logic [7:0] tp_sig = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe, irq_lvl;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clkm_a_en(clkm_a_en), .clkm_b_en(clkm_b_en), .tp_sig(tp_sig),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_lvl(irq_lvl)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] dir, input logic [1:0] ovr, input logic [7:0] tp);
        return dir | {6'b0, ovr} | tp;
    endfunction

    function automatic logic [7:0] exp_out(input logic [7:0] dout, input logic [1:0] ovr,
                                           input logic [7:0] tp, input logic [7:0] tps,
                                           input logic ca, input logic cb);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (tp[i])                 r[i] = tps[i];
            else if (i == 0 && ovr[0]) r[i] = ca;
            else if (i == 1 && ovr[1]) r[i] = cb;
            else                       r[i] = dout[i];
        end
        return r;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, dir, dout, mask, tp, eo;
        logic [1:0] ovr;
        void'($urandom(32'h5eed_61a0));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 8'h00);
        check(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 8'h00);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check(v == 8'h00, "R1 reg zero", v, 8'h00);
        end

        // R3 store and read back
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F); wr(3'd4, 8'h00);
        rd(3'd0, v); check(v == 8'hA5, "R3 dir", v, 8'hA5);
        rd(3'd1, v); check(v == 8'h3C, "R3 dout", v, 8'h3C);
        rd(3'd2, v); check(v == 8'h0F, "R3 mask", v, 8'h0F);
        // R2 direction drives data
        check(pad_oe == 8'hA5, "R2 oe", pad_oe, 8'hA5);
        check((pad_out & pad_oe) == (8'h3C & 8'hA5), "R2 out", pad_out & pad_oe, 8'h3C & 8'hA5);

        // R6 upper override bits ignored
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hFC);
        rd(3'd3, v); check(v == 8'h00, "R6 readback", v, 8'h00);
        check(pad_oe == 8'h00, "R6 pads", pad_oe, 8'h00);

        // R5 override on bits 0/1 beats direction=input
        clkm_a_en = 1'b1; clkm_b_en = 1'b0;
        wr(3'd3, 8'h03);
        check(pad_oe == 8'h03, "R5 oe", pad_oe, 8'h03);
        check(pad_out[1:0] == 2'b01, "R5 out", {6'b0, pad_out[1:0]}, 8'h01);

        // R7 testpoint beats override
        tp_sig = 8'h82;
        wr(3'd4, 8'h83);
        check(pad_oe == 8'h83, "R7 oe", pad_oe, 8'h83);
        check(pad_out == {pad_out[7:2], 2'b10} && pad_out[7] == 1'b1, "R7 out",
              pad_out & 8'h83, 8'h82);

        // R9 unmapped reads and ignored writes
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd6, v); check(v == 8'h00, "R9 addr6", v, 8'h00);
        rd(3'd7, v); check(v == 8'h00, "R9 addr7", v, 8'h00);
        rd(3'd1, v); check(v == 8'h3C, "R9 no side write", v, 8'h3C);

        // R4/R8 pin level with mask
        pad_in = 8'hF3;
        @(negedge clk); @(negedge clk);
        check(irq_lvl == 8'hF3, "R8 irq", irq_lvl, 8'hF3);
        rd(3'd5, v); check(v == 8'hF0, "R4 masked level", v, 8'hF0);

        // random mix
        for (int k = 0; k < 150; k++) begin
            dir = 8'($urandom); dout = 8'($urandom); mask = 8'($urandom);
            ovr = 2'($urandom); tp = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            tp_sig = 8'($urandom); clkm_a_en = 1'($urandom); clkm_b_en = 1'($urandom);
            wr(3'd0, dir); wr(3'd1, dout); wr(3'd2, mask);
            wr(3'd3, {6'($urandom), ovr}); wr(3'd4, tp);
            eo = exp_oe(dir, ovr, tp);
            check(pad_oe == eo, "R2/R5/R7 rand oe", pad_oe, eo);
            v = exp_out(dout, ovr, tp, tp_sig, clkm_a_en, clkm_b_en);
            check((pad_out & eo) == (v & eo), "R7 rand out", pad_out & eo, v & eo);
            pad_in = 8'($urandom);
            @(negedge clk); @(negedge clk);
            check(irq_lvl == pad_in, "R8 rand irq", irq_lvl, pad_in);
            rd(3'd5, v);
            check(v == (pad_in & ~mask), "R4 rand level", v, pad_in & ~mask);
        end

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(pad_oe == 8'h00, "R1 re-reset oe", pad_oe, 8'h00);
        rd(3'd4, v); check(v == 8'h00, "R1 re-reset tpen", v, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule